// File: doc/BRIEF.md
# Format-Tagged Floating-Point Register File

This block holds 32 floating-point registers. Each register keeps a format tag next to its data. The tag records how the value was last written: single, double, word, long, uninterpreted or unknown. There is one combinational read port and one clocked write port. Each port takes a register index and a 3-bit format code.

A read in a format that differs from the stored tag does not return the raw bits. It returns a canonical quiet NaN for the requested format and marks the register as unknown. This way, software that mixes formats on one register sees a clear poison value rather than data that silently aliases.

A mode input selects one of two register organisations. In wide mode, each register holds 64 bits. In narrow mode, each register holds 32 bits, and a double or long value uses an even/odd pair of registers. An illegal pair access raises a reserved-instruction flag on the port that made it.

Top module: `fpr_tagfile`

## Requirements
- R1: After reset, every register holds zero data and is tagged uninterpreted.
- R2: A read in format single, double, word or long (codes 0, 1, 2, 3) of a register tagged uninterpreted adopts the requested format as the new tag and returns the data.
- R3: A read in a numeric format that differs from the stored tag sets the tag to unknown. Any numeric read of an unknown register returns a quiet NaN: single 0x7FBFFFFF, word 0x7FFFFFFF, double 0x7FF7FFFFFFFFFFFF, long 0x7FFFFFFFFFFFFFFF. The 32-bit NaNs are zero-extended.
- R4: A read with format code 4, 5, 6 or 7 (uninterpreted, uninterpreted-32, uninterpreted-64, unknown) returns the raw 64-bit register contents and leaves the tag unchanged.
- R5: In wide mode (wide_mode=1), a write of single, word or uninterpreted-32 stores the value's low 32 bits in bits 31:0 and 0xDEADC0DE in bits 63:32. A matching numeric read returns only the low 32 bits, zero-extended.
- R6: In wide mode, a write of double, long, uninterpreted or uninterpreted-64 stores all 64 bits. Both uninterpreted variants are tagged plain uninterpreted.
- R7: In narrow mode (wide_mode=0), a double or long write to an even index N stores the low 32 bits in N and the high 32 bits in N+1, both zero-extended. Both tags are set to the written format. A read of N in the same format returns the two halves rejoined.
- R8: In narrow mode, a double or long access to an odd index asserts the port's reserved flag. A read returns zero. A write changes no data and sets the tags of N and N+1 to unknown.
- R9: In narrow mode, a single or word write stores the low 32 bits zero-extended and sets the tag to the written format.
- R10: A write with format code 7 (unknown) leaves the data unchanged and sets the tag to unknown.
- R11: Reads are combinational. Writes and read-caused tag changes take effect at the next rising edge. A read and a write to the same register in one cycle return the old data. If both change that register's tag, the write's tag wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: 64-bit registers, 0: 32-bit paired registers |
| rd_en | input | 1 | Read strobe; enables read-side tag updates and the read flag |
| rd_idx | input | 5 | Read register index |
| rd_fmt | input | 3 | Read format code |
| rd_data | output | 64 | Read value |
| rd_rsvd | output | 1 | Reserved-instruction flag for the read |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write register index |
| wr_fmt | input | 3 | Write format code |
| wr_data | input | 64 | Write value |
| wr_rsvd | output | 1 | Reserved-instruction flag for the write |

## Verification
The checker watches the following on every cycle:
- The read flag only rises for narrow odd accesses.
- An illegal pair write leaves an unknown tag.
- Wide half-width writes carry the fill pattern, and narrow ones carry a zero upper half.
- Wide long writes land intact.
- Every numeric read of an unknown register yields the right NaN.
- Raw reads keep the tag.

Only the bench scenarios show the following, because each one depends on an ordered history of accesses:
- Adoption of a format by an uninterpreted register.
- Splitting and rejoining of narrow pairs.
- The collapse of uninterpreted variants.
- Same-cycle read/write ordering and tag priority.

// File: rtl/fpr_tag_pkg.sv
`timescale 1ns/1ps
package fpr_tag_pkg;
  localparam int DW = 64;
  localparam int HW = DW / 2;
  localparam logic [HW-1:0] FILL_HI = 32'hDEADC0DE;

  typedef enum logic [2:0] {
    F_SINGLE = 3'd0,
    F_DOUBLE = 3'd1,
    F_WORD   = 3'd2,
    F_LONG   = 3'd3,
    F_RAW    = 3'd4,
    F_RAW32  = 3'd5,
    F_RAW64  = 3'd6,
    F_UNKN   = 3'd7
  } fmt_e;

  function automatic logic is_numeric(fmt_e f);
    return (f == F_SINGLE) || (f == F_DOUBLE) || (f == F_WORD) || (f == F_LONG);
  endfunction

  function automatic logic is_half(fmt_e f);
    return (f == F_SINGLE) || (f == F_WORD) || (f == F_RAW32);
  endfunction

  function automatic fmt_e collapse(fmt_e f);
    return (f == F_RAW32 || f == F_RAW64) ? F_RAW : f;
  endfunction

  function automatic logic [DW-1:0] quiet_nan(fmt_e f);
    case (f)
      F_SINGLE: return 64'h0000_0000_7FBF_FFFF;
      F_WORD:   return 64'h0000_0000_7FFF_FFFF;
      F_DOUBLE: return 64'h7FF7_FFFF_FFFF_FFFF;
      F_LONG:   return 64'h7FFF_FFFF_FFFF_FFFF;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/fpr_rd_dec.sv
`timescale 1ns/1ps
module fpr_rd_dec
  import fpr_tag_pkg::*;
(
  input  logic                wide_mode,
  input  logic                en,
  input  fmt_e                fmt,
  input  logic                idx_odd,
  input  fmt_e                tag,
  input  logic [DW-1:0]       word_lo,
  input  logic [HW-1:0]       word_hi,
  output logic [DW-1:0]       data,
  output logic                rsvd,
  output logic                tag_we,
  output fmt_e                tag_nxt
);
  fmt_e eff;

  always_comb begin
    data    = '0;
    rsvd    = 1'b0;
    tag_we  = 1'b0;
    tag_nxt = tag;
    eff     = tag;
    if (!is_numeric(fmt)) begin
      data = word_lo;
    end else begin
      if (tag == F_RAW)      eff = fmt;
      else if (tag != fmt)   eff = F_UNKN;
      tag_nxt = eff;
      tag_we  = en && (eff != tag);
      if (eff == F_UNKN) begin
        data = quiet_nan(fmt);
      end else if (is_half(fmt)) begin
        data = {{HW{1'b0}}, word_lo[HW-1:0]};
      end else if (wide_mode) begin
        data = word_lo;
      end else if (idx_odd) begin
        rsvd = en;
      end else begin
        data = {word_hi, word_lo[HW-1:0]};
      end
    end
  end
endmodule

// File: rtl/fpr_wr_dec.sv
`timescale 1ns/1ps
module fpr_wr_dec
  import fpr_tag_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            wide_mode,
  input  logic            en,
  input  logic [IDXW-1:0] idx,
  input  fmt_e            fmt,
  input  logic [DW-1:0]   data,
  output logic            lo_data_we,
  output logic            lo_tag_we,
  output logic [DW-1:0]   lo_data,
  output fmt_e            lo_tag,
  output logic            hi_data_we,
  output logic            hi_tag_we,
  output logic [IDXW-1:0] hi_idx,
  output logic [DW-1:0]   hi_data,
  output fmt_e            hi_tag,
  output logic            rsvd
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NREG - 1);

  always_comb begin
    lo_data_we = 1'b0;
    lo_tag_we  = en;
    lo_data    = data;
    lo_tag     = collapse(fmt);
    hi_data_we = 1'b0;
    hi_tag_we  = 1'b0;
    hi_idx     = idx + 1'b1;
    hi_data    = {{HW{1'b0}}, data[DW-1:HW]};
    hi_tag     = collapse(fmt);
    rsvd       = 1'b0;
    if (fmt == F_UNKN) begin
      lo_tag = F_UNKN;
    end else if (is_half(fmt)) begin
      lo_data_we = en;
      lo_data    = wide_mode ? {FILL_HI, data[HW-1:0]} : {{HW{1'b0}}, data[HW-1:0]};
    end else if (wide_mode) begin
      lo_data_we = en;
    end else if (!idx[0]) begin
      lo_data_we = en;
      lo_data    = {{HW{1'b0}}, data[HW-1:0]};
      hi_data_we = en;
      hi_tag_we  = en;
    end else begin
      lo_tag    = F_UNKN;
      hi_tag    = F_UNKN;
      hi_tag_we = en && (idx != LAST);
      rsvd      = en;
    end
  end
endmodule

// File: rtl/fpr_tagfile.sv
`timescale 1ns/1ps
module fpr_tagfile
  import fpr_tag_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_mode,
  input  logic            rd_en,
  input  logic [IDXW-1:0] rd_idx,
  input  logic [2:0]      rd_fmt,
  output logic [DW-1:0]   rd_data,
  output logic            rd_rsvd,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [2:0]      wr_fmt,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_rsvd
);
  logic [DW-1:0] data_q [NREG];
  fmt_e          tag_q  [NREG];

  // read side
  logic [IDXW-1:0] rd_idx_up;
  logic            rd_tag_we;
  fmt_e            rd_tag_nxt;
  logic [DW-1:0]   rd_word_hi_full;

  assign rd_idx_up       = rd_idx + 1'b1;
  assign rd_word_hi_full = data_q[rd_idx_up];

  fpr_rd_dec u_rd (
    .wide_mode (wide_mode),
    .en        (rd_en),
    .fmt       (fmt_e'(rd_fmt)),
    .idx_odd   (rd_idx[0]),
    .tag       (tag_q[rd_idx]),
    .word_lo   (data_q[rd_idx]),
    .word_hi   (rd_word_hi_full[HW-1:0]),
    .data      (rd_data),
    .rsvd      (rd_rsvd),
    .tag_we    (rd_tag_we),
    .tag_nxt   (rd_tag_nxt)
  );

  // write side
  logic            w_lo_dwe, w_lo_twe, w_hi_dwe, w_hi_twe;
  logic [DW-1:0]   w_lo_data, w_hi_data;
  fmt_e            w_lo_tag, w_hi_tag;
  logic [IDXW-1:0] w_hi_idx;

  fpr_wr_dec #(.NREG(NREG)) u_wr (
    .wide_mode  (wide_mode),
    .en         (wr_en),
    .idx        (wr_idx),
    .fmt        (fmt_e'(wr_fmt)),
    .data       (wr_data),
    .lo_data_we (w_lo_dwe),
    .lo_tag_we  (w_lo_twe),
    .lo_data    (w_lo_data),
    .lo_tag     (w_lo_tag),
    .hi_data_we (w_hi_dwe),
    .hi_tag_we  (w_hi_twe),
    .hi_idx     (w_hi_idx),
    .hi_data    (w_hi_data),
    .hi_tag     (w_hi_tag),
    .rsvd       (wr_rsvd)
  );

  // storage: write tag beats read tag on the same entry
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic lo_hit, hi_hit, rd_hit;
    assign lo_hit = (wr_idx   == IDXW'(i));
    assign hi_hit = (w_hi_idx == IDXW'(i));
    assign rd_hit = (rd_idx   == IDXW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[i] <= '0;
        tag_q[i]  <= F_RAW;
      end else begin
        if (w_lo_dwe && lo_hit)      data_q[i] <= w_lo_data;
        else if (w_hi_dwe && hi_hit) data_q[i] <= w_hi_data;
        if (w_lo_twe && lo_hit)      tag_q[i] <= w_lo_tag;
        else if (w_hi_twe && hi_hit) tag_q[i] <= w_hi_tag;
        else if (rd_tag_we && rd_hit) tag_q[i] <= rd_tag_nxt;
      end
    end
  end
endmodule

// File: rtl/fpr_tagfile_chk.sv
`timescale 1ns/1ps
module fpr_tagfile_chk
  import fpr_tag_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wide_mode,
  input logic            rd_en,
  input logic [IDXW-1:0] rd_idx,
  input logic [2:0]      rd_fmt,
  input logic [DW-1:0]   rd_data,
  input logic            rd_rsvd,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx,
  input logic [2:0]      wr_fmt,
  input logic [DW-1:0]   wr_data,
  input logic            wr_rsvd,
  input logic [DW-1:0]   data_q [NREG],
  input fmt_e            tag_q  [NREG]
);
  logic rd_numeric, wr_half;
  assign rd_numeric = is_numeric(fmt_e'(rd_fmt));
  assign wr_half    = is_half(fmt_e'(wr_fmt));

  a_r8_rd_flag_only_narrow_odd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsvd |-> (rd_en && !wide_mode && rd_idx[0]));

  a_r8_wr_flag_poisons_tag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rsvd |=> tag_q[$past(wr_idx)] == F_UNKN);

  a_r5_wide_half_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wide_mode && wr_half) |=> data_q[$past(wr_idx)][DW-1:HW] == FILL_HI);

  a_r9_narrow_half_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wide_mode && wr_half) |=> data_q[$past(wr_idx)][DW-1:HW] == '0);

  a_r6_wide_long_intact: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wide_mode && wr_fmt == 3'(F_LONG)) |=> data_q[$past(wr_idx)] == $past(wr_data));

  a_r3_unknown_reads_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_numeric && tag_q[rd_idx] == F_UNKN) |-> rd_data == quiet_nan(fmt_e'(rd_fmt)));

  a_r4_raw_read_keeps_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_numeric && !wr_en) |=> tag_q[$past(rd_idx)] == $past(tag_q[rd_idx]));
endmodule

bind fpr_tagfile fpr_tagfile_chk #(.NREG(NREG)) i_chk (
  .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
  .rd_en(rd_en), .rd_idx(rd_idx), .rd_fmt(rd_fmt), .rd_data(rd_data), .rd_rsvd(rd_rsvd),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_fmt(wr_fmt), .wr_data(wr_data), .wr_rsvd(wr_rsvd),
  .data_q(data_q), .tag_q(tag_q)
);

// File: tb/test_fpr_tagfile.sv
`timescale 1ns/1ps
module test_fpr_tagfile;
  localparam logic [2:0] S = 3'd0, D = 3'd1, W = 3'd2, L = 3'd3,
                         U = 3'd4, U32 = 3'd5, U64 = 3'd6, K = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0, wide_mode = 1'b1;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [4:0] rd_idx = '0, wr_idx = '0;
  logic [2:0] rd_fmt = '0, wr_fmt = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic rd_rsvd, wr_rsvd;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  fpr_tagfile i_fpr_tagfile (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_fmt(rd_fmt), .rd_data(rd_data), .rd_rsvd(rd_rsvd),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_fmt(wr_fmt), .wr_data(wr_data), .wr_rsvd(wr_rsvd)
  );

  function automatic logic [63:0] nan_of(logic [2:0] f);
    if (f == S) return {32'h0, 32'h7FBFFFFF};
    if (f == W) return {32'h0, 32'h7FFFFFFF};
    if (f == D) return {12'h7FF, 52'h7_FFFF_FFFF_FFFF};
    return {1'b0, {63{1'b1}}};
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] i, logic [2:0] f, logic [63:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_fmt = f; wr_data = v;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [4:0] i, logic [2:0] f, logic [63:0] exp);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = i; rd_fmt = f;
    #1 chk(req, rd_data, exp);
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic t_reset();
    rd("R1 reset raw zero", 5'd5, U, 64'h0);
    rd("R1 R2 reset single adopt", 5'd5, S, 64'h0);
    rd("R3 word after single nan", 5'd5, W, nan_of(W));
    rd("R3 unknown stays nan single", 5'd5, S, nan_of(S));
  endtask

  task automatic t_wide_half();
    wide_mode = 1'b1;
    wr(5'd2, S, 64'h12345678_3F800000);
    rd("R5 raw fill", 5'd2, U, 64'hDEADC0DE_3F800000);
    rd("R5 single read", 5'd2, S, 64'h0000_0000_3F800000);
    rd("R3 double of single nan", 5'd2, D, nan_of(D));
    wr(5'd3, W, 64'hAAAABBBB_00000007);
    rd("R5 word read", 5'd3, W, 64'h7);
  endtask

  task automatic t_wide_full();
    wide_mode = 1'b1;
    wr(5'd4, L, 64'h01234567_89ABCDEF);
    rd("R6 long read", 5'd4, L, 64'h01234567_89ABCDEF);
    rd("R3 double of long nan", 5'd4, D, nan_of(D));
    rd("R3 long after poison nan", 5'd4, L, nan_of(L));
    wr(5'd6, U64, 64'hCAFEF00D_11223344);
    rd("R6 raw64 collapses then R2 adopt", 5'd6, S, 64'h11223344);
    wr(5'd7, U32, 64'hFFFFFFFF_55667788);
    rd("R5 raw32 fill", 5'd7, U64, 64'hDEADC0DE_55667788);
    rd("R2 adopt double", 5'd7, D, 64'hDEADC0DE_55667788);
  endtask

  task automatic t_narrow();
    wide_mode = 1'b0;
    wr(5'd8, D, 64'h400921FB_54442D18);
    rd("R7 low half", 5'd8, U, 64'h54442D18);
    rd("R7 high half", 5'd9, K, 64'h400921FB);
    rd("R7 rejoined", 5'd8, D, 64'h400921FB_54442D18);
    rd("R7 pair tag double", 5'd9, S, nan_of(S));
    wr(5'd10, S, 64'hFFFF0000_3F800000);
    rd("R9 narrow single raw", 5'd10, U, 64'h3F800000);
    rd("R9 narrow single read", 5'd10, S, 64'h3F800000);
  endtask

  task automatic t_odd();
    wide_mode = 1'b0;
    @(negedge clk);
    rd_en = 1'b1; rd_idx = 5'd11; rd_fmt = D;
    #1 chk("R8 odd read flag", {63'h0, rd_rsvd}, 64'h1);
    chk("R8 odd read zero", rd_data, 64'h0);
    @(posedge clk); #1 rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd13; wr_fmt = L; wr_data = 64'h1;
    #1 chk("R8 odd write flag", {63'h0, wr_rsvd}, 64'h1);
    @(posedge clk); #1 wr_en = 1'b0;
    rd("R8 odd write data kept", 5'd13, U, 64'h0);
    rd("R8 odd tag unknown", 5'd13, S, nan_of(S));
    rd("R8 pair tag unknown", 5'd14, W, nan_of(W));
    wide_mode = 1'b1;
    rd("R8 wide no flag", 5'd11, D, 64'h0);
    chk("R8 wide no flag bit", {63'h0, rd_rsvd}, 64'h0);
  endtask

  task automatic t_unknown_write();
    wide_mode = 1'b1;
    wr(5'd16, L, 64'h55);
    wr(5'd16, K, 64'h99);
    rd("R10 data kept", 5'd16, U, 64'h55);
    rd("R10 tag unknown", 5'd16, L, nan_of(L));
  endtask

  task automatic t_same_cycle();
    wide_mode = 1'b1;
    wr(5'd20, L, 64'h1111);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = 5'd20; rd_fmt = L;
    wr_en = 1'b1; wr_idx = 5'd20; wr_fmt = L; wr_data = 64'h2222;
    #1 chk("R11 old data same cycle", rd_data, 64'h1111);
    @(posedge clk); #1 begin rd_en = 1'b0; wr_en = 1'b0; end
    rd("R11 new data next", 5'd20, L, 64'h2222);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = 5'd20; rd_fmt = W;
    wr_en = 1'b1; wr_idx = 5'd20; wr_fmt = L; wr_data = 64'h3333;
    #1 chk("R11 mismatch read nan", rd_data, nan_of(W));
    @(posedge clk); #1 begin rd_en = 1'b0; wr_en = 1'b0; end
    rd("R11 write tag wins", 5'd20, L, 64'h3333);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_wide_half();
    t_wide_full();
    t_narrow();
    t_odd();
    t_unknown_write();
    t_same_cycle();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule